// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion and error events from a bank of DMA channels and turns them into one level-sensitive interrupt, with a small register port through which software inspects, enables and acknowledges them. Every channel reports four kinds of event: end of a whole descriptor list, completion of a single descriptor node, and two separate error classes. Each kind has its own sticky raw register, its own enable mask and its own masked view. A combined word ORs the four masked views per channel.

Channels pulse one-cycle strobes on the event inputs. A node completion counts only when the descriptor that finished asked for a per-node interrupt. That request arrives on a flag input sampled with the strobe. Software reads the combined word to find which channels need service. It then reads the per-class views or raw registers and acknowledges by writing ones to the raw addresses. To halt a channel it writes that channel's bit to all four raw addresses. The register port is plain control: a write or read strobe, a byte address and data. Read data appears one cycle after the read strobe. There is no back-pressure.

Top module: `dma_irq_hub`

## Requirements
- R1: After reset every raw register and every mask is zero, `irq` is low, and every readable address returns zero.
- R2: A strobe on a channel's event input sets bit i of that class's raw register, and the bit stays set until software clears it. Class order is list-done, node-done, error A, error B (index 0 to 3).
- R3: A node-completion strobe sets the node-done raw bit only if `ch_node_irq_en` for that channel is high in the same cycle. Otherwise the raw bit is unchanged.
- R4: Writing to raw address 0x600 + 8·k (k = class index) clears exactly the bits written as one in that class. Zero bits and the other classes keep their state, so halting a channel takes one write per class.
- R5: If an event strobe and a clearing write hit the same bit in the same cycle, the bit ends set.
- R6: Writing to mask address 0x018 + 4·k replaces that class's mask. A 1 enables the channel and a 0 disables it. The mask reads back at the same address.
- R7: Address 0x004 + 4·k reads raw AND mask of class k.
- R8: Address 0x000 reads the combined word. Bit i is the OR over the four classes of raw bit i AND mask bit i.
- R9: `irq` is high exactly while the combined word is non-zero. It is a level, not a pulse.
- R10: Raw registers show latched events regardless of the masks, so they can be polled while masked.
- R11: Read data is presented on the cycle after `reg_rd_en`. Unmapped addresses read zero. Writes to them change no state. Bits above the channel count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_list_done | input | NUM_CH | Per-channel end-of-list strobe |
| ch_node_done | input | NUM_CH | Per-channel node-completion strobe |
| ch_node_irq_en | input | NUM_CH | Completing node requested an interrupt |
| ch_err_a | input | NUM_CH | Per-channel error class A strobe |
| ch_err_b | input | NUM_CH | Per-channel error class B strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults, sixteen channels and a 32-bit data word. At that size channel 15 sits at the top edge of every register, and the 16 unused upper data bits can be checked to read zero. Random event strobes, mask writes and clearing writes run against a reference model in the bench. Directed cases cover the set-versus-clear collision, the gated node event, a four-write channel halt and writes to holes in the address map.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int NUM_SRC = 4;
  localparam int ADDR_W  = 12;

  typedef enum logic [1:0] {
    SRC_LIST = 2'd0,
    SRC_NODE = 2'd1,
    SRC_ERRA = 2'd2,
    SRC_ERRB = 2'd3
  } src_e;

  localparam logic [ADDR_W-1:0] OFF_COMBINED  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VIEW_BASE = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_MASK_BASE = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_RAW_BASE  = 12'h600;

  function automatic logic [ADDR_W-1:0] view_addr(input int k);
    return OFF_VIEW_BASE + ADDR_W'(4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr(input int k);
    return OFF_MASK_BASE + ADDR_W'(4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] raw_addr(input int k);
    return OFF_RAW_BASE + ADDR_W'(8 * k);
  endfunction
endpackage

// File: rtl/dih_src_bank.sv
module dih_src_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] view
);
  logic [NUM_CH-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  // events are OR-ed in after the clear, so a colliding strobe wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~clr_bits) | evt;
      if (mask_we) mask <= wdata;
    end
  end

  assign view = raw & mask;

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  p_evt_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && |(evt & wdata)) |=> ((raw & $past(evt & wdata)) == $past(evt & wdata)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw & $past(wdata & ~evt)) == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((raw ^ $past(raw)) & ~$past(evt | clr_bits)) == '0));

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(wdata)));
endmodule

// File: rtl/dih_read_mux.sv
module dih_read_mux
  import dih_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_SRC-1:0][NUM_CH-1:0]   raw_all,
  input  logic [NUM_SRC-1:0][NUM_CH-1:0]   mask_all,
  input  logic [NUM_SRC-1:0][NUM_CH-1:0]   view_all,
  input  logic [NUM_CH-1:0]                comb,
  output logic [DATA_W-1:0]                rdata
);
  logic [NUM_CH-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == OFF_COMBINED) sel = comb;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (addr == view_addr(k)) sel = view_all[k];
      if (addr == mask_addr(k)) sel = mask_all[k];
      if (addr == raw_addr(k))  sel = raw_all[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= DATA_W'(sel);
  end

  p_raw_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == raw_addr(0)) |=> (rdata == DATA_W'($past(raw_all[0]))));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdata >> NUM_CH) == '0));
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dih_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_list_done,
  input  logic [NUM_CH-1:0] ch_node_done,
  input  logic [NUM_CH-1:0] ch_node_irq_en,
  input  logic [NUM_CH-1:0] ch_err_a,
  input  logic [NUM_CH-1:0] ch_err_b,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [11:0]       reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_SRC-1:0][NUM_CH-1:0] src_evt, raw_q, mask_q, view_q;
  logic [NUM_SRC-1:0]             clr_we, mask_we;
  logic [NUM_CH-1:0]              comb;

  // node completions only count when the descriptor asked for it
  assign src_evt[SRC_LIST] = ch_list_done;
  assign src_evt[SRC_NODE] = ch_node_done & ch_node_irq_en;
  assign src_evt[SRC_ERRA] = ch_err_a;
  assign src_evt[SRC_ERRB] = ch_err_b;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign clr_we[k]  = reg_wr_en && (reg_addr == raw_addr(k));
    assign mask_we[k] = reg_wr_en && (reg_addr == mask_addr(k));

    dih_src_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (src_evt[k]),
      .clr_we  (clr_we[k]),
      .mask_we (mask_we[k]),
      .wdata   (reg_wdata[NUM_CH-1:0]),
      .raw     (raw_q[k]),
      .mask    (mask_q[k]),
      .view    (view_q[k])
    );
  end

  always_comb begin
    comb = '0;
    for (int k = 0; k < NUM_SRC; k++) comb = comb | view_q[k];
  end

  assign irq = |comb;

  dih_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .raw_all  (raw_q),
    .mask_all (mask_q),
    .view_all (view_q),
    .comb     (comb),
    .rdata    (reg_rdata)
  );

  p_irq_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|src_evt) || $past(|mask_we)));

  p_irq_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(|clr_we) || $past(|mask_we)));

  p_node_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we[SRC_NODE] && ((ch_node_done & ~ch_node_irq_en & ~raw_q[SRC_NODE]) != '0))
      |=> ((raw_q[SRC_NODE] & $past(ch_node_done & ~ch_node_irq_en & ~raw_q[SRC_NODE])) == '0));
endmodule

// File: tb/dma_irq_hub_tb.sv
module dma_irq_hub_tb_top;
  localparam int N  = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ch_list_done = '0, ch_node_done = '0, ch_node_irq_en = '0;
  logic [N-1:0]  ch_err_a = '0, ch_err_b = '0;
  logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] m_raw [4];
  logic [N-1:0] m_mask[4];

  always #10 clk = ~clk;

  dma_irq_hub #(.NUM_CH(N), .DATA_W(DW)) dut_i (.*);

  function automatic logic [11:0] a_raw(int k);  return 12'(32'h600 + 8*k); endfunction
  function automatic logic [11:0] a_mask(int k); return 12'(32'h018 + 4*k); endfunction
  function automatic logic [11:0] a_view(int k); return 12'(32'h004 + 4*k); endfunction

  function automatic logic [N-1:0] m_comb();
    logic [N-1:0] c = '0;
    for (int k = 0; k < 4; k++) c |= m_raw[k] & m_mask[k];
    return c;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [11:0] a);
    logic [N-1:0] v = '0;
    if (a == 12'h000) v = m_comb();
    for (int k = 0; k < 4; k++) begin
      if (a == a_view(k)) v = m_raw[k] & m_mask[k];
      if (a == a_mask(k)) v = m_mask[k];
      if (a == a_raw(k))  v = m_raw[k];
    end
    return DW'(v);
  endfunction

  function automatic string tag(logic [11:0] a);
    if (a == 12'h000) return "R8";
    for (int k = 0; k < 4; k++) begin
      if (a == a_view(k)) return "R7";
      if (a == a_mask(k)) return "R6";
      if (a == a_raw(k))  return "R10";
    end
    return "R11";
  endfunction

  function automatic logic [11:0] pick_addr(int i);
    case (i)
      0: return 12'h000;  1: return a_view(0); 2: return a_view(1);
      3: return a_view(2); 4: return a_view(3); 5: return a_mask(0);
      6: return a_mask(1); 7: return a_mask(2); 8: return a_mask(3);
      9: return a_raw(0); 10: return a_raw(1); 11: return a_raw(2);
      12: return a_raw(3); 13: return 12'h014; 14: return 12'h604;
      default: return 12'h028;
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [11:0] a, logic [DW-1:0] d,
                     logic [N-1:0] el, logic [N-1:0] en, logic [N-1:0] nf,
                     logic [N-1:0] ea, logic [N-1:0] eb);
    logic [N-1:0] ev[4];
    @(negedge clk);
    reg_wr_en = we; reg_addr = a; reg_wdata = d;
    ch_list_done = el; ch_node_done = en; ch_node_irq_en = nf;
    ch_err_a = ea; ch_err_b = eb;
    @(posedge clk);
    #2;
    reg_wr_en = 0; ch_list_done = '0; ch_node_done = '0;
    ch_node_irq_en = '0; ch_err_a = '0; ch_err_b = '0;
    ev[0] = el; ev[1] = en & nf; ev[2] = ea; ev[3] = eb;
    for (int k = 0; k < 4; k++) begin
      logic [N-1:0] clr = (we && a == a_raw(k)) ? d[N-1:0] : '0;
      m_raw[k] = (m_raw[k] & ~clr) | ev[k];
      if (we && a == a_mask(k)) m_mask[k] = d[N-1:0];
    end
  endtask

  task automatic wr(logic [11:0] a, logic [DW-1:0] d);
    cyc(1'b1, a, d, '0, '0, '0, '0, '0);
  endtask

  task automatic rd_chk(logic [11:0] a, string req);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(posedge clk);
    #2 reg_rd_en = 0;
    @(negedge clk);
    chk(req, reg_rdata, exp_rd(a));
  endtask

  task automatic irq_chk(string req);
    @(negedge clk);
    chk(req, DW'(irq), DW'(m_comb() != '0));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset state
    irq_chk("R1");
    for (int i = 0; i < 13; i++) rd_chk(pick_addr(i), "R1");

    // R2 / R10: events latch while masked, irq stays low
    cyc(0, 0, 0, 16'h8001, 0, 0, 16'h0100, 16'h0020);
    rd_chk(a_raw(0), "R2"); rd_chk(a_raw(2), "R10"); rd_chk(a_raw(3), "R2");
    irq_chk("R9");
    // R3: node event gated by flag
    cyc(0, 0, 0, 0, 16'h00F0, 16'h0030, 0, 0);
    rd_chk(a_raw(1), "R3");
    // R6/R7/R8/R9: enable masks
    wr(a_mask(0), 32'hFFFF_8000);
    rd_chk(a_mask(0), "R6"); rd_chk(a_view(0), "R7"); rd_chk(12'h000, "R8");
    irq_chk("R9");
    // R5: collision, event wins
    cyc(1, a_raw(0), 32'h0000_8001, 16'h8000, 0, 0, 0, 0);
    rd_chk(a_raw(0), "R5");
    // R11: unmapped write changes nothing
    wr(12'h014, 32'hFFFF_FFFF); wr(12'h604, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) rd_chk(pick_addr(i), "R11");
    rd_chk(12'h028, "R11");
    // R4: halt channel 5 with one write per class
    cyc(0, 0, 0, 16'h0020, 16'h0020, 16'h0020, 16'h0020, 16'h0020);
    for (int k = 0; k < 4; k++) wr(a_raw(k), 32'h0000_0020);
    for (int k = 0; k < 4; k++) rd_chk(a_raw(k), "R4");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        cyc(0, 0, 0, N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
            N'($urandom), N'($urandom) & N'($urandom) & N'($urandom),
            N'($urandom) & N'($urandom) & N'($urandom));
      end else if (op < 6) begin
        int k = $urandom_range(0, 3);
        cyc(1, a_raw(k), $urandom, N'($urandom) & N'($urandom), 0, 0, 0, 0);
      end else if (op == 6) begin
        wr(a_mask($urandom_range(0, 3)), $urandom);
      end else begin
        logic [11:0] a = pick_addr($urandom_range(0, 15));
        rd_chk(a, tag(a));
        irq_chk("R9");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule